// File: doc/BRIEF.md
# Four-Pin Bidirectional Port with Layered Reset Conditions

This block is a small general-purpose I/O port of four pins. Each pin has a direction bit, which makes it an input or an output, and an output latch bit, which holds the level the pin drives. A processor-side register interface can load the direction register, load the latch, or set or clear a single latch bit. The pad side has an input level, an output level and an output enable for each pin.

Reading the port returns the pad levels after a two-stage synchronizer, not the latch contents. The single-bit set and clear operations work on that pad read. All four latch bits are rewritten, so an output pin that something outside holds against its latch loses its latch value.

Four system conditions act on the port. Power-on reset is asynchronous. It makes every pin an input and loads the latch with a fixed arbitrary pattern. A chip-enable reset and a clock stop both turn every pin into an input, keep the latch, and block register writes. During clock stop the input buffers are also gated off, so reads return zero, unless a parameter exempts the port. Halt freezes direction, latch and pin drive, and blocks writes.

Top module: `quad_io_port`

## Requirements
- R1: While power-on reset (`rstPorN` low) is asserted and right after it, `padOe` is 0 on every pin, `padOut` shows the parameter `PowerOnLatch` (default 4'b1010), and `rdData` is 0.
- R2: A write with `wrOp` = 2'b00 loads `wrData` into the direction register at the clock edge. Outside any forced-input condition, `padOe` equals the direction register (1 = output).
- R3: A write with `wrOp` = 2'b01 loads `wrData` into the output latch at the clock edge, and `padOut` shows it in the following cycle.
- R4: A write with `wrOp` = 2'b10 sets the latch to the current `rdData` with bit `bitSel` forced to 1. All four latch bits are rewritten.
- R5: A write with `wrOp` = 2'b11 sets the latch to the current `rdData` with bit `bitSel` forced to 0. An output pin whose pad is held low from outside therefore gets its latch bit cleared.
- R6: While `ceReset` is high, `padOe` is 0 in the same cycle and the direction register clears at the clock edge. The latch keeps its value, and register writes have no effect.
- R7: While `clkStop` is high, `padOe` is 0, the direction register clears and the latch is kept. Register writes have no effect. With `GateExempt` = 0 (default), `rdData` reads 0.
- R8: While `halt` is high, direction, latch and `padOe` keep their values, and register writes have no effect.
- R9: Outside clock-stop gating, `rdData` equals `padIn` as it was two clock edges earlier, whatever the pin directions are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rstPorN | input | 1 | Asynchronous power-on reset, active low |
| ceReset | input | 1 | Chip-enable reset condition |
| clkStop | input | 1 | Clock-stop condition |
| halt | input | 1 | Halt condition |
| wrEn | input | 1 | Register write strobe |
| wrOp | input | 2 | 00 direction, 01 latch, 10 bit set, 11 bit clear |
| wrData | input | 4 | Data for direction or latch loads |
| bitSel | input | 2 | Bit index for set and clear |
| rdData | output | 4 | Synchronized pad levels, gated in clock stop |
| padIn | input | 4 | Pad input levels |
| padOut | output | 4 | Pad output levels from the latch |
| padOe | output | 4 | Pad output enables |

## Verification
A corrupted direction register shows up on `padOe` in the cycle after the faulty edge. A corrupted latch shows up on `padOut` at the same point. A wrong synchronizer stage or wrong gating appears on `rdData` within two edges. A bad read-modify-write leaves a wrong latch bit that is visible one cycle after the set or clear. The bench compares all three outputs every cycle against a model built from the requirements. This confines a fault to the cycle in which it happened.

// File: rtl/quad_io_pkg.sv
package quad_io_pkg;

  typedef enum logic [1:0] {
    OP_DIR = 2'b00,
    OP_LAT = 2'b01,
    OP_SET = 2'b10,
    OP_CLR = 2'b11
  } portOp_e;

  typedef struct packed {
    logic forceIn;  // all pins forced to input, direction clears
    logic gateIn;   // input buffers gated off
    logic ldDir;
    logic ldLatch;
    logic rmwSet;
    logic rmwClr;
  } portCtl_t;

endpackage

// File: rtl/quad_io_ctrl.sv
module quad_io_ctrl
  import quad_io_pkg::*;
#(
  parameter bit GateExempt = 1'b0
) (
  input  logic       clk,
  input  logic       rstPorN,
  input  logic       ceReset,
  input  logic       clkStop,
  input  logic       halt,
  input  logic       wrEn,
  input  logic [1:0] wrOp,
  output portCtl_t   ctl
);

  logic    wrAllowed;
  portOp_e opCode;

  assign opCode    = portOp_e'(wrOp);
  assign wrAllowed = wrEn && !ceReset && !clkStop && !halt;

  always_comb begin
    ctl         = '0;
    ctl.forceIn = ceReset | clkStop;
    ctl.gateIn  = clkStop & ~GateExempt;
    if (wrAllowed) begin
      unique case (opCode)
        OP_DIR: ctl.ldDir   = 1'b1;
        OP_LAT: ctl.ldLatch = 1'b1;
        OP_SET: ctl.rmwSet  = 1'b1;
        OP_CLR: ctl.rmwClr  = 1'b1;
        default: ;
      endcase
    end
  end

  // R8: no write strobe leaves control while halted
  a_r8_halt_blocks_writes: assert property (@(posedge clk) disable iff (!rstPorN)
    halt |-> !(ctl.ldDir || ctl.ldLatch || ctl.rmwSet || ctl.rmwClr));

  // R6 / R7: at most one strobe, and none while forced to input
  a_r6_forced_no_writes: assert property (@(posedge clk) disable iff (!rstPorN)
    (ceReset || clkStop) |-> !(ctl.ldDir || ctl.ldLatch || ctl.rmwSet || ctl.rmwClr));

  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rstPorN)
    $onehot0({ctl.ldDir, ctl.ldLatch, ctl.rmwSet, ctl.rmwClr}));

endmodule

// File: rtl/quad_io_dp.sv
module quad_io_dp
  import quad_io_pkg::*;
#(
  parameter int              Width        = 4,
  parameter int              SyncDepth    = 2,
  parameter logic [Width-1:0] PowerOnLatch = 4'b1010,
  localparam int             IdxW         = (Width > 1) ? $clog2(Width) : 1
) (
  input  logic             clk,
  input  logic             rstPorN,
  input  portCtl_t         ctl,
  input  logic [Width-1:0] wrData,
  input  logic [IdxW-1:0]  bitSel,
  input  logic [Width-1:0] padIn,
  output logic [Width-1:0] rdData,
  output logic [Width-1:0] dirQ,
  output logic [Width-1:0] latchQ
);

  logic [Width-1:0] syncQ [SyncDepth];
  logic [Width-1:0] bitMask;
  logic [Width-1:0] pinRead;

  // input synchronizer chain
  for (genvar s = 0; s < SyncDepth; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstPorN) begin
        if (!rstPorN) syncQ[0] <= '0;
        else          syncQ[0] <= padIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstPorN) begin
        if (!rstPorN) syncQ[s] <= '0;
        else          syncQ[s] <= syncQ[s-1];
      end
    end
  end

  assign pinRead = ctl.gateIn ? '0 : syncQ[SyncDepth-1];
  assign rdData  = pinRead;
  assign bitMask = Width'(1) << bitSel;

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      dirQ <= '0;
    end else if (ctl.forceIn) begin
      dirQ <= '0;
    end else if (ctl.ldDir) begin
      dirQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      latchQ <= PowerOnLatch;
    end else if (ctl.ldLatch) begin
      latchQ <= wrData;
    end else if (ctl.rmwSet) begin
      latchQ <= pinRead | bitMask;
    end else if (ctl.rmwClr) begin
      latchQ <= pinRead & ~bitMask;
    end
  end

  // R6 / R7: forced input clears direction at the next edge
  a_r6_dir_cleared: assert property (@(posedge clk) disable iff (!rstPorN)
    ctl.forceIn |=> (dirQ == '0));

  // R3: latch moves only on a latch-changing strobe
  a_r3_latch_hold: assert property (@(posedge clk) disable iff (!rstPorN)
    !(ctl.ldLatch || ctl.rmwSet || ctl.rmwClr) |=> $stable(latchQ));

  // R4: targeted bit ends up high after a set
  a_r4_set_bit: assert property (@(posedge clk) disable iff (!rstPorN)
    ctl.rmwSet |=> latchQ[$past(bitSel)]);

  // R5: targeted bit ends up low after a clear
  a_r5_clr_bit: assert property (@(posedge clk) disable iff (!rstPorN)
    ctl.rmwClr |=> !latchQ[$past(bitSel)]);

  // R7: gated buffers read as zero
  a_r7_gated_zero: assert property (@(posedge clk) disable iff (!rstPorN)
    ctl.gateIn |-> (rdData == '0));

endmodule

// File: rtl/quad_io_port.sv
module quad_io_port
  import quad_io_pkg::*;
#(
  parameter int              Width        = 4,
  parameter int              SyncDepth    = 2,
  parameter logic [Width-1:0] PowerOnLatch = 4'b1010,
  parameter bit              GateExempt   = 1'b0,
  localparam int             IdxW         = (Width > 1) ? $clog2(Width) : 1
) (
  input  logic             clk,
  input  logic             rstPorN,
  input  logic             ceReset,
  input  logic             clkStop,
  input  logic             halt,
  input  logic             wrEn,
  input  logic [1:0]       wrOp,
  input  logic [Width-1:0] wrData,
  input  logic [IdxW-1:0]  bitSel,
  output logic [Width-1:0] rdData,
  input  logic [Width-1:0] padIn,
  output logic [Width-1:0] padOut,
  output logic [Width-1:0] padOe
);

  portCtl_t         ctl;
  logic [Width-1:0] dirQ;
  logic [Width-1:0] latchQ;

  quad_io_ctrl #(.GateExempt(GateExempt)) u_ctrl (
    .clk     (clk),
    .rstPorN (rstPorN),
    .ceReset (ceReset),
    .clkStop (clkStop),
    .halt    (halt),
    .wrEn    (wrEn),
    .wrOp    (wrOp),
    .ctl     (ctl)
  );

  quad_io_dp #(
    .Width        (Width),
    .SyncDepth    (SyncDepth),
    .PowerOnLatch (PowerOnLatch)
  ) u_dp (
    .clk     (clk),
    .rstPorN (rstPorN),
    .ctl     (ctl),
    .wrData  (wrData),
    .bitSel  (bitSel),
    .padIn   (padIn),
    .rdData  (rdData),
    .dirQ    (dirQ),
    .latchQ  (latchQ)
  );

  assign padOut = latchQ;
  assign padOe  = dirQ & ~{Width{ctl.forceIn}};

  // R6 / R7: no pin drives during a forced-input condition
  a_r7_no_drive_forced: assert property (@(posedge clk) disable iff (!rstPorN)
    (ceReset || clkStop) |-> (padOe == '0));

  // R8: halt keeps the pin drive unchanged
  a_r8_halt_hold: assert property (@(posedge clk) disable iff (!rstPorN)
    (halt && !ceReset && !clkStop && $past(halt && !ceReset && !clkStop))
      |-> $stable(padOe) && $stable(padOut));

endmodule

// File: tb/sim_quad_io_port.sv
`timescale 1ns/1ps
module sim_quad_io_port;

  logic       clk = 1'b0;
  logic       rstPorN = 1'b0;
  logic       ceReset = 1'b0, clkStop = 1'b0, halt = 1'b0, wrEn = 1'b0;
  logic [1:0] wrOp = 2'b00, bitSel = 2'b00;
  logic [3:0] wrData = 4'h0, padIn = 4'h0;
  logic [3:0] rdData, padOut, padOe;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // bench model state
  logic [3:0] eDir, eLatch, s1, s2;

  always #5 clk = ~clk;

  quad_io_port u0 (
    .clk(clk), .rstPorN(rstPorN), .ceReset(ceReset), .clkStop(clkStop),
    .halt(halt), .wrEn(wrEn), .wrOp(wrOp), .wrData(wrData), .bitSel(bitSel),
    .rdData(rdData), .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  task automatic chk(input string tag, input string what,
                     input logic [3:0] got, input logic [3:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, got, exp, $time);
    end
  endtask

  function automatic logic [3:0] rmwResult(input logic [3:0] rd, input logic [1:0] idx,
                                           input bit setIt);
    logic [3:0] m = 4'b0001 << idx;
    return setIt ? (rd | m) : (rd & ~m);
  endfunction

  // one clock cycle: drive at negedge, update model, check at next negedge
  task automatic cycle(input bit ce, input bit cs, input bit hl, input bit we,
                       input logic [1:0] op, input logic [3:0] d,
                       input logic [1:0] sel, input logic [3:0] pin);
    bit force_, canWr;
    logic [3:0] pr;
    string tagOe, tagOut, tagRd;
    ceReset = ce; clkStop = cs; halt = hl; wrEn = we;
    wrOp = op; wrData = d; bitSel = sel; padIn = pin;
    force_ = ce | cs;
    canWr  = we && !force_ && !hl;
    pr     = cs ? 4'h0 : s2;
    tagOe  = ce ? "R6" : cs ? "R7" : hl ? "R8" : "R2";
    tagOut = ce ? "R6" : cs ? "R7" : hl ? "R8" :
             !we ? "R3" : op == 2'b10 ? "R4" : op == 2'b11 ? "R5" : "R3";
    if (force_) eDir = 4'h0;
    else if (canWr && op == 2'b00) eDir = d;
    if (canWr) begin
      case (op)
        2'b01: eLatch = d;
        2'b10: eLatch = rmwResult(pr, sel, 1'b1);
        2'b11: eLatch = rmwResult(pr, sel, 1'b0);
        default: ;
      endcase
    end
    s2 = s1; s1 = pin;
    @(posedge clk);
    @(negedge clk);
    tagRd = cs ? "R7" : "R9";
    chk(tagOe,  "padOe",  padOe,  force_ ? 4'h0 : eDir);
    chk(tagOut, "padOut", padOut, eLatch);
    chk(tagRd,  "rdData", rdData, cs ? 4'h0 : s2);
  endtask

  task automatic idle(input logic [3:0] pin);
    cycle(0, 0, 0, 0, 2'b00, 4'h0, 2'b00, pin);
  endtask

  initial begin : watchdog
    #1_000_000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] r;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1: state held under power-on reset
    chk("R1", "padOe in reset",  padOe,  4'h0);
    chk("R1", "padOut in reset", padOut, 4'b1010);
    chk("R1", "rdData in reset", rdData, 4'h0);
    rstPorN = 1'b1;
    eDir = 4'h0; eLatch = 4'b1010; s1 = 4'h0; s2 = 4'h0;
    @(negedge clk);
    chk("R1", "padOe after reset", padOe, 4'h0);

    // latch first, then direction (no drive before the latch write)
    cycle(0, 0, 0, 1, 2'b01, 4'b0011, 2'b00, 4'b0011);
    chk("R1", "no drive before direction write", padOe, 4'h0);
    cycle(0, 0, 0, 1, 2'b00, 4'b0011, 2'b00, 4'b0011);
    chk("R2", "outputs enabled", padOe, 4'b0011);

    // R5: pin 0 pulled low from outside, clear of bit 1 wipes latch bit 0
    idle(4'b0010); idle(4'b0010);
    cycle(0, 0, 0, 1, 2'b11, 4'h0, 2'b01, 4'b0010);
    chk("R5", "rmw corruption", padOut, 4'b0000);

    // R4: set bit 3 from pad read
    idle(4'b0101); idle(4'b0101);
    cycle(0, 0, 0, 1, 2'b10, 4'h0, 2'b11, 4'b0101);
    chk("R4", "set from pad", padOut, 4'b1101);

    // R8: halt holds everything, write ignored
    cycle(0, 0, 1, 1, 2'b01, 4'b0110, 2'b00, 4'b0101);
    chk("R8", "halt ignores latch write", padOut, 4'b1101);
    chk("R8", "halt keeps drive", padOe, 4'b0011);

    // R6: chip-enable reset, latch retained
    cycle(1, 0, 0, 1, 2'b01, 4'b0000, 2'b00, 4'b0101);
    chk("R6", "latch retained", padOut, 4'b1101);
    idle(4'b0101);
    chk("R6", "direction cleared", padOe, 4'h0);

    // R7: clock stop with gated reads
    cycle(0, 0, 0, 1, 2'b00, 4'b1111, 2'b00, 4'b1111);
    cycle(0, 1, 0, 1, 2'b01, 4'b0000, 2'b00, 4'b1111);
    cycle(0, 1, 0, 0, 2'b00, 4'h0, 2'b00, 4'b1111);
    chk("R7", "gated read", rdData, 4'h0);
    chk("R7", "latch retained", padOut, 4'b1101);
    idle(4'b1111); idle(4'b1111);
    chk("R9", "read restored", rdData, 4'b1111);

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      r = $urandom;
      cycle(r[3:0] == 4'h0, r[7:4] == 4'h1, r[11:8] < 4'd2, r[12],
            r[14:13], r[18:15], r[20:19], r[24:21]);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule